// File: doc/BRIEF.md
# Serial Port Register Window

This block is the software-visible face of a serial port. It occupies a 4 KiB window on a simple 32-bit register bus: one address, a write strobe with write data, and a read strobe whose result appears on the read-data port one clock later. Received bytes arrive on an input byte stream and wait in a 16-entry queue until software reads the data register. Writes to the data register leave on an output byte stream with a valid/ready handshake.

An 11-bit raw interrupt status register collects receive, transmit and overrun events. Software can read it, mask it, read its masked form and clear bits by writing ones to a separate clear register. A single level interrupt output is high whenever any unmasked raw bit is set. Baud, line, control, level-select, low-power-counter and DMA settings are plain storage registers. They hold what is written, cut to their field widths, and drive nothing. Eight identification registers near the top of the window return fixed bytes.

Top module: `uart_regwin`

## Requirements
- R1: After reset, every storage register, the receive status register, the mask and the raw status read 0, the interrupt output is 0, and the flag register at 0x18 reads 0x090 (transmit-empty bit 7 and receive-empty bit 4 set).
- R2: The storage registers hold written data cut to their widths and read it back. The offsets and widths are 0x20 (8 bits), 0x24 (16), 0x28 (6), 0x2C (8), 0x30 (16), 0x34 (6) and 0x48 (3). The mask register at 0x38 keeps 11 bits.
- R3: Reads of 0xFE0, 0xFE4, 0xFE8, 0xFEC, 0xFF0, 0xFF4, 0xFF8 and 0xFFC return 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05 and 0xB1.
- R4: Reads of unmapped offsets, and reads of the clear register at 0x44, return 0. Writes to 0x18, 0x3C, 0x40 and unmapped offsets change nothing visible.
- R5: An input byte taken while the queue is not full is appended in arrival order. It clears receive-empty (flag bit 4) and sets the receive interrupt bit 4 of the raw status at 0x3C.
- R6: A read of the data register at 0x00 returns the oldest queued byte and removes it, or returns 0 when the queue is empty. The read that empties the queue sets receive-empty and clears raw bit 4.
- R7: With 16 bytes queued, flag bit 6 (receive-full) is set. A further input byte is dropped. It sets the overrun bit 10 of the raw status and bit 3 of the receive status register at 0x04.
- R8: A write of any value to 0x04 clears the receive status register to zero.
- R9: A write to 0x00 while no byte is waiting to leave puts wdata[7:0] on the output stream and holds it, valid, until ready. It sets the transmit interrupt bit 5. While the byte waits, flag bits 5 and 3 are set, and a further data write is dropped. Flag bit 7 stays 1.
- R10: A read of 0x40 returns the raw status ANDed with the mask. The interrupt output is 1 exactly when that AND is nonzero.
- R11: A write to 0x44 clears each raw status bit written as 1 and leaves the others. A hardware event in the same cycle wins over the clear.
- R12: Read data appears on the read-data port in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| rx_valid | input | 1 | Incoming byte present this cycle |
| rx_byte | input | 8 | Incoming byte |
| tx_valid | output | 1 | Outgoing byte waiting |
| tx_byte | output | 8 | Outgoing byte |
| tx_ready | input | 1 | Consumer accepts the outgoing byte |
| irq | output | 1 | Level interrupt, any unmasked raw bit set |

## Verification
The hardest state to reach from the ports is overrun. The queue must hold exactly 16 bytes with no read between the last push and one more input byte. The drop must then be shown twice: in the raw and receive-status bits, and in the absence of the seventeenth byte when the queue is drained. A directed sequence empties the queue, fills it to the brim, pushes once more and reads everything back. Constrained-random traffic then mixes pushes, pops, mask and clear writes against a queue-and-status model kept in the bench, so the full, drained and overrun edges are met again under varied masks.

// File: rtl/uart_regwin_pkg.sv
package uart_regwin_pkg;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;
  localparam int IRQ_W  = 11;
  localparam int RSR_W  = 4;
  localparam int FLAG_W = 9;

  // register offsets (software-visible contract)
  localparam logic [ADDR_W-1:0] OFS_DATA    = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_RXSTAT  = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_FLAGS   = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_IMASK   = 12'h038;
  localparam logic [ADDR_W-1:0] OFS_IRAW    = 12'h03C;
  localparam logic [ADDR_W-1:0] OFS_IMASKED = 12'h040;
  localparam logic [ADDR_W-1:0] OFS_ICLEAR  = 12'h044;
  localparam logic [ADDR_W-1:0] OFS_IDENT   = 12'hFE0;

  // plain storage registers: offset and width
  localparam int NSTORE = 7;
  localparam logic [ADDR_W-1:0] STORE_OFS [NSTORE] =
    '{12'h020, 12'h024, 12'h028, 12'h02C, 12'h030, 12'h034, 12'h048};
  localparam int STORE_W [NSTORE] = '{8, 16, 6, 8, 16, 6, 3};

  // interrupt bit positions
  localparam int IB_OVERRUN = 10;
  localparam int IB_TX      = 5;
  localparam int IB_RX      = 4;

  // flag bit positions
  localparam int FB_TXEMPTY = 7;
  localparam int FB_RXFULL  = 6;
  localparam int FB_TXFULL  = 5;
  localparam int FB_RXEMPTY = 4;
  localparam int FB_BUSY    = 3;

  // receive status overrun position
  localparam int RS_OVERRUN = 3;

  function automatic logic [DATA_W-1:0] width_mask(input int w);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < DATA_W; i++) if (i < w) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [BYTE_W-1:0] ident_byte(input logic [ADDR_W-1:0] a);
    case (a)
      12'hFE0: return 8'h11;
      12'hFE4: return 8'h10;
      12'hFE8: return 8'h14;
      12'hFEC: return 8'h00;
      12'hFF0: return 8'h0D;
      12'hFF4: return 8'hF0;
      12'hFF8: return 8'h05;
      12'hFFC: return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [FLAG_W-1:0] pack_flags(input logic tx_empty, input logic rx_full,
                                                   input logic tx_full, input logic rx_empty,
                                                   input logic busy);
    logic [FLAG_W-1:0] f;
    f = '0;
    f[FB_TXEMPTY] = tx_empty;
    f[FB_RXFULL]  = rx_full;
    f[FB_TXFULL]  = tx_full;
    f[FB_RXEMPTY] = rx_empty;
    f[FB_BUSY]    = busy;
    return f;
  endfunction

  // raw status update: clear first, hardware events win
  function automatic logic [IRQ_W-1:0] next_raw(input logic [IRQ_W-1:0] raw,
                                                input logic [IRQ_W-1:0] set_v,
                                                input logic [IRQ_W-1:0] clr_v);
    return (raw & ~clr_v) | set_v;
  endfunction

endpackage

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full,
  output logic             accepted,
  output logic             dropped,
  output logic             drained
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
  localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    count_q;
  logic             pop_eff;

  assign empty    = (count_q == '0);
  assign full     = (count_q == CNT_FULL);
  assign pop_eff  = pop && !empty;
  assign accepted = push && (!full || pop_eff);
  assign dropped  = push && !accepted;
  assign drained  = pop_eff && (count_q == CW'(1)) && !accepted;
  assign head     = empty ? '0 : mem_q[rd_ptr_q];

  function automatic logic [PW-1:0] ptr_step(input logic [PW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (accepted) wr_ptr_q <= ptr_step(wr_ptr_q);
      if (pop_eff)  rd_ptr_q <= ptr_step(rd_ptr_q);
      case ({accepted, pop_eff})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accepted) mem_q[wr_ptr_q] <= push_data;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_FULL); // R7
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full); // R7
endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
  import uart_regwin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] set_vec,
  input  logic [IRQ_W-1:0] clr_vec,
  input  logic             mask_we,
  input  logic [IRQ_W-1:0] mask_wdata,
  output logic [IRQ_W-1:0] raw,
  output logic [IRQ_W-1:0] mask,
  output logic [IRQ_W-1:0] masked,
  output logic             irq
);
  logic [IRQ_W-1:0] raw_q, mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= next_raw(raw_q, set_vec, clr_vec);
      if (mask_we) mask_q <= mask_wdata;
    end
  end

  assign raw    = raw_q;
  assign mask   = mask_q;
  assign masked = raw_q & mask_q;
  assign irq    = |masked;

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec)) |=> ((raw_q & $past(clr_vec & ~set_vec)) == '0)); // R11
  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((raw_q & $past(set_vec)) == $past(set_vec))); // R11
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_data,
  output logic             loaded,
  output logic             tx_valid,
  output logic [WIDTH-1:0] tx_byte,
  input  logic             tx_ready
);
  logic             valid_q;
  logic [WIDTH-1:0] byte_q;

  assign loaded = load && (!valid_q || tx_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      byte_q  <= '0;
    end else begin
      if (loaded) begin
        valid_q <= 1'b1;
        byte_q  <= load_data;
      end else if (tx_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign tx_valid = valid_q;
  assign tx_byte  = byte_q;

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte))); // R9
endmodule

// File: rtl/uart_store_reg.sv
module uart_store_reg
  import uart_regwin_pkg::*;
#(
  parameter int                WIDTH = 8,
  parameter logic [ADDR_W-1:0] OFS   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] value
);
  localparam logic [DATA_W-1:0] KEEP = width_mask(WIDTH);
  logic [DATA_W-1:0] val_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  val_q <= '0;
    else if (wr && addr == OFS)  val_q <= wdata & KEEP;
  end

  assign value = val_q;

  AST_WIDTH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (val_q & ~KEEP) == '0); // R2
endmodule

// File: rtl/uart_regwin.sv
module uart_regwin
  import uart_regwin_pkg::*;
#(
  parameter int RX_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_ready,
  output logic              irq
);
  // access decode
  logic wr_data, wr_rxstat, wr_mask, wr_clear, rd_data;
  assign wr_data   = bus_wr && (bus_addr == OFS_DATA);
  assign wr_rxstat = bus_wr && (bus_addr == OFS_RXSTAT);
  assign wr_mask   = bus_wr && (bus_addr == OFS_IMASK);
  assign wr_clear  = bus_wr && (bus_addr == OFS_ICLEAR);
  assign rd_data   = bus_rd && (bus_addr == OFS_DATA);

  // receive queue and its events
  logic [BYTE_W-1:0] q_head;
  logic q_empty, q_full, q_accept, q_drop, q_drained;

  uart_rx_queue #(.DEPTH(RX_DEPTH), .WIDTH(BYTE_W)) rxq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (rx_valid),
    .push_data (rx_byte),
    .pop       (rd_data),
    .head      (q_head),
    .empty     (q_empty),
    .full      (q_full),
    .accepted  (q_accept),
    .dropped   (q_drop),
    .drained   (q_drained)
  );

  // transmit holding stage
  logic tx_loaded;
  uart_tx_hold #(.WIDTH(BYTE_W)) txh_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (wr_data),
    .load_data (bus_wdata[BYTE_W-1:0]),
    .loaded    (tx_loaded),
    .tx_valid  (tx_valid),
    .tx_byte   (tx_byte),
    .tx_ready  (tx_ready)
  );

  // interrupt events
  logic [IRQ_W-1:0] ev_set, ev_clr, raw_st, mask_st, masked_st;
  always_comb begin
    ev_set = '0;
    ev_set[IB_RX]      = q_accept;
    ev_set[IB_OVERRUN] = q_drop;
    ev_set[IB_TX]      = tx_loaded;
    ev_clr = wr_clear ? bus_wdata[IRQ_W-1:0] : '0;
    ev_clr[IB_RX] = ev_clr[IB_RX] | q_drained;
  end

  uart_irq_unit irq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_vec    (ev_set),
    .clr_vec    (ev_clr),
    .mask_we    (wr_mask),
    .mask_wdata (bus_wdata[IRQ_W-1:0]),
    .raw        (raw_st),
    .mask       (mask_st),
    .masked     (masked_st),
    .irq        (irq)
  );

  // receive status
  logic [RSR_W-1:0] rxstat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxstat_q <= '0;
    end else begin
      if (wr_rxstat) rxstat_q <= '0;
      if (q_drop)    rxstat_q[RS_OVERRUN] <= 1'b1;
    end
  end

  // storage registers
  logic [NSTORE-1:0][DATA_W-1:0] store_val;
  for (genvar g = 0; g < NSTORE; g++) begin : g_store
    uart_store_reg #(.WIDTH(STORE_W[g]), .OFS(STORE_OFS[g])) reg_i (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (bus_wr),
      .addr  (bus_addr),
      .wdata (bus_wdata),
      .value (store_val[g])
    );
  end

  // flags
  logic [FLAG_W-1:0] flags;
  assign flags = pack_flags(1'b1, q_full, tx_valid, q_empty, tx_valid);

  // read mux
  logic [DATA_W-1:0] rd_value;
  always_comb begin
    rd_value = '0;
    case (bus_addr)
      OFS_DATA:    rd_value = DATA_W'(q_head);
      OFS_RXSTAT:  rd_value = DATA_W'(rxstat_q);
      OFS_FLAGS:   rd_value = DATA_W'(flags);
      OFS_IMASK:   rd_value = DATA_W'(mask_st);
      OFS_IRAW:    rd_value = DATA_W'(raw_st);
      OFS_IMASKED: rd_value = DATA_W'(masked_st);
      default: begin
        if (bus_addr >= OFS_IDENT) rd_value = DATA_W'(ident_byte(bus_addr));
        for (int i = 0; i < NSTORE; i++)
          if (bus_addr == STORE_OFS[i]) rd_value = store_val[i];
      end
    endcase
  end

  logic [DATA_W-1:0] rdata_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_value;
  end
  assign bus_rdata = rdata_q;

  AST_RX_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    q_accept |=> raw_st[IB_RX]); // R5
  AST_DRAIN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    q_drained |=> (!raw_st[IB_RX] && flags[FB_RXEMPTY])); // R6
  AST_DROP_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    q_drop |=> (raw_st[IB_OVERRUN] && rxstat_q[RS_OVERRUN])); // R7
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R12
  AST_TXE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    flags[FB_TXEMPTY]); // R9
endmodule

// File: tb/uart_regwin_tb_top.sv
module uart_regwin_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        tx_valid;
  logic [7:0]  tx_byte;
  logic        tx_ready = 1'b0;
  logic        irq;

  always #4 clk = ~clk;

  uart_regwin dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .tx_ready(tx_ready), .irq(irq)
  );

  int n_chk = 0;
  int n_err = 0;

  // bench model
  logic [7:0]  mq [16];
  int          mcount = 0;
  logic [10:0] mraw = '0;
  logic [10:0] mmask = '0;
  logic [3:0]  mrsr = '0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_flags(input int cnt);
    logic [31:0] f;
    f = 32'h80;
    if (cnt == 16) f[6] = 1'b1;
    if (cnt == 0)  f[4] = 1'b1;
    return f;
  endfunction

  // all tasks start and end at a falling edge
  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic push_byte(input logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
    if (mcount < 16) begin
      mq[mcount] = b; mcount++; mraw[4] = 1'b1;
    end else begin
      mraw[10] = 1'b1; mrsr[3] = 1'b1;
    end
  endtask

  function automatic logic [7:0] model_pop();
    logic [7:0] b;
    if (mcount == 0) return 8'h00;
    b = mq[0];
    for (int i = 0; i < 15; i++) mq[i] = mq[i+1];
    mcount--;
    if (mcount == 0) mraw[4] = 1'b0;
    return b;
  endfunction

  task automatic pop_check(input string tag);
    logic [31:0] d;
    logic [7:0]  e;
    e = model_pop();
    bus_read(12'h000, d);
    check(tag, d, {24'h0, e});
  endtask

  task automatic check_irq(input string tag);
    check(tag, {31'h0, irq}, {31'h0, |(mraw & mmask)});
  endtask

  logic [31:0] rd;
  int unsigned seed_dummy;

  localparam logic [11:0] SOFS [7] = '{12'h020, 12'h024, 12'h028, 12'h02C, 12'h030, 12'h034, 12'h048};
  localparam logic [31:0] SMSK [7] = '{32'hFF, 32'hFFFF, 32'h3F, 32'hFF, 32'hFFFF, 32'h3F, 32'h7};
  localparam logic [11:0] IOFS [8] = '{12'hFE0, 12'hFE4, 12'hFE8, 12'hFEC, 12'hFF0, 12'hFF4, 12'hFF8, 12'hFFC};
  localparam logic [7:0]  IVAL [8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    seed_dummy = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 tx_valid", {31'h0, tx_valid}, 32'h0);
    bus_read(12'h018, rd); check("R1 flags", rd, 32'h90);
    bus_read(12'h03C, rd); check("R1 raw", rd, 32'h0);
    bus_read(12'h038, rd); check("R1 mask", rd, 32'h0);
    bus_read(12'h004, rd); check("R1 rxstat", rd, 32'h0);
    for (int i = 0; i < 7; i++) begin
      bus_read(SOFS[i], rd); check("R1 storage", rd, 32'h0);
    end

    // R2: storage widths
    for (int i = 0; i < 7; i++) begin
      bus_write(SOFS[i], 32'hFFFF_FFFF);
      bus_read(SOFS[i], rd); check("R2 all-ones", rd, SMSK[i]);
      begin
        logic [31:0] v;
        v = $urandom();
        bus_write(SOFS[i], v);
        bus_read(SOFS[i], rd); check("R2 random", rd, v & SMSK[i]);
      end
    end
    bus_write(12'h038, 32'hFFFF_FFFF);
    bus_read(12'h038, rd); check("R2 mask width", rd, 32'h7FF);
    bus_write(12'h038, 32'h0);

    // R3: identification
    for (int i = 0; i < 8; i++) begin
      bus_read(IOFS[i], rd); check("R3 ident", rd, {24'h0, IVAL[i]});
    end

    // R4: unmapped and read-only
    bus_read(12'h008, rd); check("R4 unmapped 0x008", rd, 32'h0);
    bus_read(12'h04C, rd); check("R4 unmapped 0x04C", rd, 32'h0);
    bus_read(12'hFDC, rd); check("R4 unmapped 0xFDC", rd, 32'h0);
    bus_read(12'h044, rd); check("R4 clear reads 0", rd, 32'h0);
    bus_write(12'h018, 32'hFFFF_FFFF);
    bus_write(12'h03C, 32'hFFFF_FFFF);
    bus_write(12'h040, 32'hFFFF_FFFF);
    bus_write(12'h100, 32'hFFFF_FFFF);
    bus_read(12'h018, rd); check("R4 flags untouched", rd, 32'h90);
    bus_read(12'h03C, rd); check("R4 raw untouched", rd, 32'h0);
    bus_read(12'h040, rd); check("R4 masked untouched", rd, 32'h0);
    check("R4 irq untouched", {31'h0, irq}, 32'h0);

    // R5/R6: push, order, drain
    push_byte(8'h3C); push_byte(8'hA7);
    bus_read(12'h018, rd); check("R5 rx not empty", rd, exp_flags(mcount));
    bus_read(12'h03C, rd); check("R5 raw rx bit", rd, {21'h0, mraw});
    pop_check("R6 oldest first");
    bus_read(12'h03C, rd); check("R6 rx bit stays", rd, 32'h10);
    pop_check("R6 second byte");
    bus_read(12'h03C, rd); check("R6 rx bit cleared", rd, 32'h0);
    bus_read(12'h018, rd); check("R6 rx empty", rd, 32'h90);
    pop_check("R6 empty read zero");

    // R12: read latency and hold
    bus_addr = 12'hFE0; bus_rd = 1'b1;
    #1 check("R12 not yet", bus_rdata, 32'h0);
    @(negedge clk); bus_rd = 1'b0; bus_addr = 12'hFF0;
    check("R12 after edge", bus_rdata, 32'h11);
    @(negedge clk);
    check("R12 held", bus_rdata, 32'h11);

    // R7: fill, overrun, drain
    for (int i = 0; i < 16; i++) push_byte(8'(8'h40 + i));
    bus_read(12'h018, rd); check("R7 full flag", rd, 32'hC0);
    push_byte(8'hEE);
    bus_read(12'h03C, rd); check("R7 overrun raw", rd, 32'h410);
    bus_read(12'h004, rd); check("R7 rxstat overrun", rd, 32'h8);
    for (int i = 0; i < 16; i++) pop_check("R7 drain order");
    pop_check("R7 dropped byte absent");
    bus_read(12'h018, rd); check("R7 empty after drain", rd, 32'h90);

    // R8: clear receive status
    bus_write(12'h004, 32'h0); mrsr = '0;
    bus_read(12'h004, rd); check("R8 rxstat cleared", rd, 32'h0);

    // R11: clear register
    bus_write(12'h044, 32'h400); mraw[10] = 1'b0;
    bus_read(12'h03C, rd); check("R11 w1c", rd, {21'h0, mraw});

    // R9: transmit path
    tx_ready = 1'b0;
    bus_write(12'h000, 32'h0000_01A5); mraw[5] = 1'b1;
    check("R9 tx valid", {31'h0, tx_valid}, 32'h1);
    check("R9 tx byte", {24'h0, tx_byte}, 32'hA5);
    bus_read(12'h018, rd); check("R9 busy flags", rd, 32'hB8);
    bus_read(12'h03C, rd); check("R9 tx irq bit", rd, 32'h20);
    bus_write(12'h000, 32'h77);
    check("R9 stalled write dropped", {24'h0, tx_byte}, 32'hA5);
    tx_ready = 1'b1;
    @(negedge clk);
    check("R9 handshake done", {31'h0, tx_valid}, 32'h0);
    bus_read(12'h018, rd); check("R9 idle flags", rd, 32'h90);

    // R10: mask and irq
    bus_write(12'h038, 32'h020); mmask = 11'h020;
    bus_read(12'h040, rd); check("R10 masked", rd, 32'h20);
    check_irq("R10 irq high");
    bus_write(12'h044, 32'h020); mraw[5] = 1'b0;
    check_irq("R10 irq low after clear");

    // random traffic, tx always ready
    for (int it = 0; it < 3000; it++) begin
      int op;
      logic [31:0] v;
      op = int'($urandom_range(0, 7));
      v = $urandom();
      case (op)
        0, 1: push_byte(v[7:0]);
        2: pop_check("R6 random pop");
        3: begin bus_write(12'h038, v); mmask = v[10:0]; end
        4: begin bus_write(12'h044, v); mraw = mraw & ~v[10:0]; end
        5: begin bus_read(12'h040, rd); check("R10 random masked", rd, {21'h0, mraw & mmask}); end
        6: begin bus_read(12'h018, rd); check("R5 random flags", rd, exp_flags(mcount)); end
        default: begin
          bus_write(12'h000, v); mraw[5] = 1'b1;
          check("R9 random tx byte", {24'h0, tx_byte}, {24'h0, v[7:0]});
          @(negedge clk);
        end
      endcase
      check_irq("R10 random irq");
      if (it % 50 == 0) begin
        bus_read(12'h03C, rd); check("R11 random raw", rd, {21'h0, mraw});
        bus_read(12'h004, rd); check("R7 random rxstat", rd, {28'h0, mrsr});
      end
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule